// File: doc/BRIEF.md
# Task-Pulsed Timer/Counter with Compare Channels

This block is a timer/counter peripheral controlled by one-cycle task pulses. There are tasks to start, stop, clear, count and shut down, plus one capture task for each channel. In timer mode the count advances on a clock enable divided down by a power of two. In counter mode the count advances only on count pulses. The counter width (8, 16, 24 or 32 bits) is chosen at run time, and the count wraps at that width.

Each of the `NCH` channels holds a compare value. A capture task loads the current count into that value. A match sets a sticky event flag. Each channel can also clear or stop the counter on a match. A per-channel one-shot option limits a channel to one event per write of its compare value. A level interrupt is high whenever an enabled event flag is set.

Software programs the block through a single-cycle write port. Register reads are combinational.

Top module: `task_timer`

## Requirements
- R1: After reset the counter is stopped and holds 0. Every readable register reads 0 and `irq` is low.
- R2: In timer mode (mode register value 0) with prescaler p, the count rises by one every 2^p clock cycles while running. The first increment lands 2^p edges after the edge that sampled the start task.
- R3: In counter mode (any nonzero mode value), each cycle with `task_count` high adds one, but only while running. A count pulse is ignored when the counter is stopped or in timer mode.
- R4: Width register codes select the counter width: 0 selects 16 bits, 1 selects 8, 2 selects 24 and 3 selects 32. The count wraps to 0 after the largest value of the selected width.
- R5: Stop holds the count. A later start continues from the held value.
- R6: Clear zeroes the count whether the counter is running or stopped. Shutdown stops the counter and zeroes the count. Tasks in the same cycle take effect in this order: shutdown, clear, stop, start, then count/tick. When any of the first four is present, that cycle's count/tick is dropped.
- R7: A capture pulse on channel n writes the count held before that edge, masked to the selected width, into compare register n. Capture wins over a same-cycle register write.
- R8: A channel matches when the incremented count equals its compare value masked to the width. A match sets that channel's event flag. The flag stays set until software writes it, and the written bit 0 becomes the new flag value.
- R9: The shortcut register holds a clear-on-match bit for channel n at bit n and a stop-on-match bit at bit 8+n. On a match, clear is applied first, so the count becomes 0 instead of the matched value. Stop is applied next, and the event flag is still set.
- R10: When one-shot bit n is set, channel n raises only the first match after a write to its compare register. Its shortcuts are suppressed on later matches. Writing the compare register again re-arms the channel.
- R11: `irq` is high exactly when some channel has both its event flag and its enable set. Writing 1s to the enable-set address ORs them into the enables, and that address reads back the enables. Writing 1s to the enable-clear address clears those enables, and that address always reads 0.
- R12: The register map uses word addresses: 0 mode, 1 width, 2 prescaler, 3 shortcuts, 4 one-shot enables, 5 enable-set, 6 enable-clear, 8+n event flag n in bit 0, 16+n compare value n. Unmapped addresses read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| task_start | input | 1 | Start pulse |
| task_stop | input | 1 | Stop pulse |
| task_clear | input | 1 | Clear pulse |
| task_count | input | 1 | Count pulse (counter mode) |
| task_shutdown | input | 1 | Stop-and-zero pulse |
| task_capture | input | NCH | Capture pulse per channel |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 5 | Register word address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Combinational read data for `reg_addr` |
| irq | output | 1 | Level interrupt |

## Verification
A task or write sampled at a rising edge updates state at that edge, and the result is readable in the following cycle. A capture stores the count from before that edge. An event flag and the interrupt it drives are visible right after the edge that made the matching increment. In timer mode the first tick arrives 2^p edges after the start edge, so a run whose start and stop are sampled W edges apart holds (W-1)>>p ticks. The bench drives every input on the falling edge and reads combinational outputs shortly after. It probes the count with a capture into the last channel followed by a read, which keeps every sample one full cycle after the edge that produced it.

// File: rtl/task_timer.sv
module task_timer #(
  parameter int NCH   = 4,
  parameter int PSC_W = 4
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           task_start,
  input  logic           task_stop,
  input  logic           task_clear,
  input  logic           task_count,
  input  logic           task_shutdown,
  input  logic [NCH-1:0] task_capture,
  input  logic           reg_we,
  input  logic [4:0]     reg_addr,
  input  logic [31:0]    reg_wdata,
  output logic [31:0]    reg_rdata,
  output logic           irq
);
  localparam int DIV_W  = (1 << PSC_W) - 1;
  localparam int A_MODE = 0, A_WID = 1, A_PSC = 2, A_SHORT = 3, A_ONE = 4;
  localparam int A_ENS  = 5, A_ENC = 6, A_EVT = 8, A_CC = 16;
  localparam int STP_OFS = 8;

  logic [1:0]       mode_q, width_q;
  logic [PSC_W-1:0] psc_q;
  logic [NCH-1:0]   shclr_q, shstp_q, osen_q, inten_q, evt_q, armed_q;
  logic [31:0]      cc_q [NCH];
  logic [31:0]      cnt_q;
  logic             run_q;
  logic [DIV_W-1:0] div_q;

  logic [31:0]      cmask, nxt;
  logic [DIV_W-1:0] psc_mask;
  logic             ctr_mode, ctrl, tick, adv, sc_clr, sc_stp;
  logic [NCH-1:0]   hit;

  always_comb
    case (width_q)
      2'd0:    cmask = 32'h0000_FFFF;
      2'd1:    cmask = 32'h0000_00FF;
      2'd2:    cmask = 32'h00FF_FFFF;
      default: cmask = 32'hFFFF_FFFF;
    endcase

  assign ctr_mode = (mode_q != 2'd0);
  assign ctrl     = task_shutdown | task_clear | task_stop | task_start;
  assign psc_mask = (DIV_W'(1) << psc_q) - DIV_W'(1);
  assign tick     = ((div_q & psc_mask) == psc_mask);
  assign adv      = run_q && !ctrl && (ctr_mode ? task_count : tick);
  assign nxt      = (cnt_q + 32'd1) & cmask;

  always_comb
    for (int n = 0; n < NCH; n++)
      hit[n] = adv && (nxt == (cc_q[n] & cmask)) && (!osen_q[n] || armed_q[n]);

  assign sc_clr = |(hit & shclr_q);
  assign sc_stp = |(hit & shstp_q);
  assign irq    = |(evt_q & inten_q);

  // counter core with task priority
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      cnt_q <= '0;
      run_q <= 1'b0;
      div_q <= '0;
    end else if (task_shutdown) begin
      cnt_q <= '0;
      run_q <= 1'b0;
      div_q <= '0;
    end else if (task_clear) begin
      cnt_q <= '0;
      div_q <= '0;
      if (task_stop)       run_q <= 1'b0;
      else if (task_start) run_q <= 1'b1;
    end else if (task_stop) begin
      run_q <= 1'b0;
    end else if (task_start) begin
      if (!run_q) begin
        run_q <= 1'b1;
        div_q <= '0;
      end
    end else begin
      if (run_q && !ctr_mode) div_q <= div_q + DIV_W'(1);
      if (adv) begin
        cnt_q <= sc_clr ? 32'd0 : nxt;
        if (sc_stp) run_q <= 1'b0;
      end
    end

  // configuration registers
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      mode_q  <= '0;
      width_q <= '0;
      psc_q   <= '0;
      shclr_q <= '0;
      shstp_q <= '0;
      osen_q  <= '0;
      inten_q <= '0;
    end else if (reg_we) begin
      case (int'(reg_addr))
        A_MODE:  mode_q  <= reg_wdata[1:0];
        A_WID:   width_q <= reg_wdata[1:0];
        A_PSC:   psc_q   <= reg_wdata[PSC_W-1:0];
        A_SHORT: begin
          shclr_q <= reg_wdata[NCH-1:0];
          shstp_q <= reg_wdata[STP_OFS +: NCH];
        end
        A_ONE:   osen_q  <= reg_wdata[NCH-1:0];
        A_ENS:   inten_q <= inten_q | reg_wdata[NCH-1:0];
        A_ENC:   inten_q <= inten_q & ~reg_wdata[NCH-1:0];
        default: ;
      endcase
    end

  // per-channel compare, capture, one-shot and event state
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      for (int n = 0; n < NCH; n++) cc_q[n] <= '0;
      evt_q   <= '0;
      armed_q <= '0;
    end else begin
      for (int n = 0; n < NCH; n++) begin
        if (task_capture[n])
          cc_q[n] <= cnt_q & cmask;
        else if (reg_we && reg_addr == 5'(A_CC + n))
          cc_q[n] <= reg_wdata;

        if (reg_we && reg_addr == 5'(A_CC + n) && !task_capture[n])
          armed_q[n] <= 1'b1;
        else if (hit[n])
          armed_q[n] <= 1'b0;

        if (hit[n])
          evt_q[n] <= 1'b1;
        else if (reg_we && reg_addr == 5'(A_EVT + n))
          evt_q[n] <= reg_wdata[0];
      end
    end

  always_comb begin
    reg_rdata = '0;
    case (int'(reg_addr))
      A_MODE:  reg_rdata = {30'd0, mode_q};
      A_WID:   reg_rdata = {30'd0, width_q};
      A_PSC:   reg_rdata = 32'(psc_q);
      A_SHORT: reg_rdata = (32'(shstp_q) << STP_OFS) | 32'(shclr_q);
      A_ONE:   reg_rdata = 32'(osen_q);
      A_ENS:   reg_rdata = 32'(inten_q);
      default: ;
    endcase
    for (int n = 0; n < NCH; n++) begin
      if (reg_addr == 5'(A_EVT + n)) reg_rdata = {31'd0, evt_q[n]};
      if (reg_addr == 5'(A_CC + n))  reg_rdata = cc_q[n];
    end
  end

  assert_shutdown_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
    task_shutdown |=> (cnt_q == 32'd0 && !run_q));

  assert_clear_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
    task_clear |=> (cnt_q == 32'd0));

  assert_hold_stopped_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!run_q && !task_clear && !task_shutdown) |=> $stable(cnt_q));

  assert_single_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!task_clear && !task_shutdown) |=>
      (cnt_q == $past(cnt_q) || cnt_q == 32'd0 ||
       cnt_q == (($past(cnt_q) + 32'd1) & $past(cmask))));

  assert_event_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !reg_we |=> ((evt_q & $past(evt_q)) == $past(evt_q)));

  assert_count_ignored_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!run_q || !ctr_mode) && !task_clear && !task_shutdown && !tick |=> $stable(cnt_q));
endmodule

// File: tb/task_timer_tb_top.sv
module task_timer_tb_top;
  localparam int NCH = 4;
  logic clk = 0, rst_n = 0;
  logic t_start = 0, t_stop = 0, t_clear = 0, t_count = 0, t_shut = 0;
  logic [NCH-1:0] t_cap = '0;
  logic reg_we = 0;
  logic [4:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0, reg_rdata;
  logic irq;
  int total = 0, bad = 0;
  bit done = 0;

  always #2 clk = ~clk;

  task_timer #(.NCH(NCH), .PSC_W(4)) dut_i (
    .clk(clk), .rst_n(rst_n), .task_start(t_start), .task_stop(t_stop),
    .task_clear(t_clear), .task_count(t_count), .task_shutdown(t_shut),
    .task_capture(t_cap), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq));

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input int a, input logic [31:0] d);
    @(negedge clk); reg_we = 1; reg_addr = 5'(a); reg_wdata = d;
    @(negedge clk); reg_we = 0;
  endtask

  task automatic rd(input int a, output logic [31:0] d);
    @(negedge clk); reg_addr = 5'(a); #1; d = reg_rdata;
  endtask

  // bits: {shutdown, clear, stop, start, count}
  task automatic pulse(input logic [4:0] b);
    @(negedge clk); {t_shut, t_clear, t_stop, t_start, t_count} = b;
    @(negedge clk); {t_shut, t_clear, t_stop, t_start, t_count} = '0;
  endtask

  task automatic counts(input int n);
    if (n > 0) begin
      @(negedge clk); t_count = 1;
      repeat (n) @(negedge clk);
      t_count = 0;
    end
  endtask

  task automatic cap(input int ch);
    @(negedge clk); t_cap = NCH'(1) << ch;
    @(negedge clk); t_cap = '0;
  endtask

  task automatic getcnt(output logic [31:0] v);
    cap(NCH - 1);
    rd(16 + NCH - 1, v);
  endtask

  task automatic run_timer(input int w);
    @(negedge clk); t_start = 1;
    @(negedge clk); t_start = 0;
    repeat (w - 1) @(negedge clk);
    t_stop = 1;
    @(negedge clk); t_stop = 0;
  endtask

  function automatic logic [31:0] wmask(input int w);
    case (w)
      0: return 32'h0000_FFFF;
      1: return 32'h0000_00FF;
      2: return 32'h00FF_FFFF;
      default: return 32'hFFFF_FFFF;
    endcase
  endfunction

  initial begin
    #(4 * 190000);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1;

    // R1 reset state
    for (int a = 0; a < 32; a++) begin rd(a, v); chk("R1 reset reg", v, 0); end
    chk("R1 irq", 32'(irq), 0);
    getcnt(v); chk("R1 count", v, 0);

    // R12 register map
    wr(0, 2); rd(0, v); chk("R12 mode", v, 2);
    wr(2, 9); rd(2, v); chk("R12 psc", v, 9);
    wr(3, 32'h0000_0A05); rd(3, v); chk("R12 shortcuts", v, 32'h0A05);
    wr(4, 6); rd(4, v); chk("R12 oneshot", v, 6);
    wr(3, 0); wr(4, 0); rd(7, v); chk("R12 unmapped", v, 0);

    // R3/R4 counter mode 8-bit wrap
    wr(0, 1); wr(1, 1); pulse(5'b00010);
    counts(255); getcnt(v); chk("R4 8bit max", v, 255);
    counts(1); getcnt(v); chk("R4 8bit wrap", v, 0);

    // R5 stop holds, start resumes; R3 ignored when stopped
    counts(5); pulse(5'b00100);
    counts(3); getcnt(v); chk("R3 ignored stopped", v, 5);
    pulse(5'b00010); counts(4); getcnt(v); chk("R5 resume", v, 9);

    // R7/R4 capture masking across widths and channels
    wr(1, 0); pulse(5'b01000); counts(300); pulse(5'b00100);
    for (int w = 0; w < 4; w++) begin
      wr(1, w);
      for (int ch = 0; ch < NCH; ch++) begin
        cap(ch); rd(16 + ch, v); chk("R7 capture", v, 300 & wmask(w));
      end
    end
    wr(1, 0);
    @(negedge clk); t_cap = 4'b0001; reg_we = 1; reg_addr = 16; reg_wdata = 77;
    @(negedge clk); t_cap = 0; reg_we = 0;
    rd(16, v); chk("R7 capture beats write", v, 300);

    // R6 clear stopped / running, priority
    pulse(5'b01000); getcnt(v); chk("R6 clear stopped", v, 0);
    pulse(5'b00010); counts(4); pulse(5'b01000); getcnt(v); chk("R6 clear running", v, 0);
    counts(1); getcnt(v); chk("R6 still running", v, 1);
    counts(6); pulse(5'b01111); getcnt(v); chk("R6 prio clear", v, 0);
    counts(2); getcnt(v); chk("R6 stop beats start", v, 0);
    pulse(5'b00011); getcnt(v); chk("R6 count dropped", v, 0);
    counts(1); getcnt(v); chk("R6 started", v, 1);
    pulse(5'b10010); counts(2); getcnt(v); chk("R6 shutdown", v, 0);

    // R2 timer mode sweep over prescaler
    wr(0, 0);
    for (int p = 0; p < 6; p++) begin
      wr(2, p); pulse(5'b01000); run_timer(37);
      getcnt(v); chk("R2 timer ticks", v, 32'((37 - 1) >> p));
    end
    // R3 count pulses ignored in timer mode
    wr(2, 15); pulse(5'b01000); pulse(5'b00010); counts(5); pulse(5'b00100);
    getcnt(v); chk("R3 ignored timer mode", v, 0);
    // R4 16-bit wrap in timer mode
    wr(2, 0); pulse(5'b01000); run_timer(65541);
    getcnt(v); chk("R4 16bit wrap", v, 4);

    // R8 compare events
    wr(0, 1); wr(1, 0);
    for (int ch = 0; ch < 3; ch++) begin
      pulse(5'b01000); wr(8 + ch, 0);
      wr(16 + ch, (ch << 16) | (5 + ch));
      pulse(5'b00010);
      counts(4 + ch); rd(8 + ch, v); chk("R8 no early event", v, 0);
      counts(1); rd(8 + ch, v); chk("R8 event", v, 1);
      counts(3); rd(8 + ch, v); chk("R8 sticky", v, 1);
      wr(8 + ch, 0); rd(8 + ch, v); chk("R8 cleared", v, 0);
      pulse(5'b00100);
    end

    // R9 shortcuts
    wr(16, 200); wr(17, 3); wr(9, 0); wr(3, 32'h2);
    pulse(5'b01010); counts(3); getcnt(v); chk("R9 clear short", v, 0);
    rd(9, v); chk("R9 event with clear", v, 1);
    counts(2); getcnt(v); chk("R9 keeps running", v, 2);
    wr(18, 4); wr(10, 0); wr(3, 32'h400);
    pulse(5'b01000); counts(4); getcnt(v); chk("R9 stop short", v, 4);
    counts(3); getcnt(v); chk("R9 stopped", v, 4);
    rd(10, v); chk("R9 event with stop", v, 1);
    wr(3, 0);

    // R10 one-shot
    wr(4, 1); wr(16, 2); wr(8, 0);
    pulse(5'b01010); counts(2); rd(8, v); chk("R10 first match", v, 1);
    wr(8, 0); pulse(5'b01000); counts(2); rd(8, v); chk("R10 suppressed", v, 0);
    wr(16, 2); pulse(5'b01000); counts(2); rd(8, v); chk("R10 rearmed", v, 1);
    wr(4, 0); pulse(5'b00100);

    // R11 exhaustive event x enable
    for (int e = 0; e < 16; e++)
      for (int m = 0; m < 16; m++) begin
        for (int ch = 0; ch < NCH; ch++) wr(8 + ch, (e >> ch) & 1);
        wr(6, 32'hF); wr(5, m);
        #1; chk("R11 irq level", 32'(irq), 32'((e & m) != 0));
        rd(5, v); chk("R11 enable readback", v, m);
        rd(6, v); chk("R11 clear reads zero", v, 0);
      end
    wr(5, 32'hF); wr(6, 32'h5); rd(5, v); chk("R11 partial clear", v, 32'hA);

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule